// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block derives a set of output clocks from a fast reference clock and turns groups of them off and on without producing shortened or lengthened pulses. All outputs share one divider, so every running output toggles in phase with every other. Three output groups exist. The bus group always obeys the bus stop request. The free group has one mask bit per output, and that bit decides whether the output follows the bus stop request or keeps running. The processor group follows its own stop pin. An active-low power-down pin halts every group.

The bus stop request combines an active-low pin with an active-low control bit: the clocks stop when either of them is low. A small register port lets software set the control bit, the free-output mask and a bit that selects whether the processor outputs are driven or released (output enable low) while they are halted. Reading the control register returns the combined stop state. All asynchronous pins pass through two-flop synchronisers. Gating decisions are made only at divider edges while an output is low, so a stopped output always parks low after a complete high phase, and a restarting output always begins with a full high phase aligned to the shared divider.

Top module: `clkstop_ctrl`

## Requirements
- R1: After reset, the control register reads 1 (bit 0 = 1, bit 1 = 0), the mask register at address 1 reads all ones in its low FREE_N bits, and every output runs: it goes high at the HALF-th rising reference edge after reset is released and then toggles every HALF reference cycles.
- R2: Bit 0 of a read at address 0 returns the logical AND of the bus stop pin and the written control bit 0. A change of the pin shows in this bit after exactly two rising reference edges.
- R3: While the bus stop pin is low or control bit 0 is 0, every bus output is held low, and it is parked no later than 2 + 2*HALF reference cycles after the request.
- R4: While the bus stop is requested, a free output whose mask bit (address 1, bit j for output j) is 1 keeps running, and one whose mask bit is 0 is held low like a bus output.
- R5: Every high pulse on any output lasts exactly HALF reference cycles, whether the output is starting, stopping or running.
- R6: After the stop request is removed, the stopped outputs are running again and in phase with the shared divider no later than 2 + 2*HALF reference cycles later, which is never more than two output periods.
- R7: The processor outputs are held low while the processor stop pin is low. Control bit 1 set to 1 makes their output enable low while they are parked; with bit 1 at 0, or while they run, the enable stays high.
- R8: While the power-down pin is low, all outputs are held low, including free outputs whose mask bit is 1, and the processor output enable follows the rule of R7.
- R9: Addresses 2 and 3 read as zero, and writes to them change neither the control nor the mask register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_stop_n_i | input | 1 | Asynchronous active-low bus stop pin |
| cpu_stop_n_i | input | 1 | Asynchronous active-low processor stop pin |
| pwrdn_n_i | input | 1 | Asynchronous active-low power-down pin |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for reads and writes |
| wr_data_i | input | max(FREE_N,2) | Write data |
| rd_data_o | output | max(FREE_N,2) | Read data for addr_i (combinational) |
| bus_clk_o | output | BUS_N | Bus group clocks |
| free_clk_o | output | FREE_N | Free group clocks |
| cpu_clk_o | output | CPU_N | Processor group clocks |
| cpu_oe_o | output | CPU_N | Processor output enables |

## Verification
Readback of the combined stop bit is due two rising edges after a pin change and immediately after the write edge of the control bit, so the bench samples it at the falling edge after one edge (old value) and after two (new value). Output gating is due within 2 + 2*HALF cycles of the last pin change, so every checking window starts only after that many cycles and then compares each output at each falling edge with an in-phase expectation derived from the cycle count since reset. The release bound of R6 is checked at exactly that cycle, and a pulse-width monitor measures every high phase on one output of each group throughout the run.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    localparam int unsigned ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;

    // Control register contents.
    typedef struct packed {
        logic cpu_hiz;   // release processor outputs while parked
        logic bus_run;   // active-low bus stop bit (1 = run)
    } ctrl_t;

    // Synchronised stop requests, active high.
    typedef struct packed {
        logic bus_stop;
        logic cpu_stop;
        logic pwr_down;
    } req_t;

    function automatic int unsigned data_width(input int unsigned free_n);
        return (free_n > 2) ? free_n : 2;
    endfunction

    function automatic logic free_allow(input req_t r, input logic keep_running);
        return !r.pwr_down && (keep_running || !r.bus_stop);
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/clkstop_div.sv
`timescale 1ns/1ps
module clkstop_div #(
    parameter int unsigned HALF = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o,   // divider edge on the next clock
    output logic rise_o    // that edge is a rising one
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          ph_q;

    assign tick_o = (cnt_q == LAST);
    assign rise_o = tick_o && !ph_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (tick_o) begin
            cnt_q <= '0;
            ph_q  <= !ph_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: divider edges are spaced HALF cycles apart
    p_tick_gap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> ((HALF == 1) || !tick_o))
        else $error("divider edges too close");
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic rise_i,
    input  logic allow_i,
    output logic clk_o,
    output logic parked_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            clk_o    <= 1'b0;
            parked_o <= 1'b0;
        end else if (tick_i && clk_o) begin
            clk_o <= 1'b0;              // finish the high phase in full
        end else if (rise_i) begin
            clk_o    <= allow_i;        // decide only while low
            parked_o <= !allow_i;
        end
    end

    // R3: a parked output is low
    p_park_low_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        parked_o |-> !clk_o)
        else $error("parked output is high");

    // R3: a blocked low output stays low
    p_stay_low_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!allow_i && !clk_o) |=> !clk_o)
        else $error("blocked output rose");

    // R5: a high phase lasts until the divider edge
    p_hold_high_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (clk_o && !tick_i) |=> clk_o)
        else $error("high phase cut short");
endmodule

// File: rtl/clkstop_regs.sv
`timescale 1ns/1ps
module clkstop_regs
    import clkstop_pkg::*;
#(
    parameter int unsigned FREE_N = 3,
    localparam int unsigned DW = data_width(FREE_N)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic              bus_pin_i,   // synchronised, active low
    output ctrl_t             ctrl_o,
    output logic [FREE_N-1:0] mask_o,
    output logic [DW-1:0]     rd_data_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_o <= '{cpu_hiz: 1'b0, bus_run: 1'b1};
            mask_o <= '1;
        end else if (wr_en_i) begin
            unique case (addr_i)
                ADDR_CTRL: begin
                    ctrl_o.bus_run <= wr_data_i[0];
                    ctrl_o.cpu_hiz <= wr_data_i[1];
                end
                ADDR_MASK: mask_o <= wr_data_i[FREE_N-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data_o = '0;
        unique case (addr_i)
            ADDR_CTRL: begin
                rd_data_o[0] = bus_pin_i && ctrl_o.bus_run;
                rd_data_o[1] = ctrl_o.cpu_hiz;
            end
            ADDR_MASK: rd_data_o[FREE_N-1:0] = mask_o;
            default: ;
        endcase
    end

    // R2: a cleared run bit always reads back as stopped
    p_run_clear_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (addr_i == ADDR_CTRL && !ctrl_o.bus_run) |-> !rd_data_o[0])
        else $error("stop bit reads as running");

    // R9: writes elsewhere leave the registers untouched
    p_unmapped_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && addr_i[1]) |=> ($stable(ctrl_o) && $stable(mask_o)))
        else $error("unmapped write changed a register");
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int unsigned HALF   = 2,
    parameter int unsigned BUS_N  = 4,
    parameter int unsigned FREE_N = 3,
    parameter int unsigned CPU_N  = 2
) (
    input  logic                                   clk_i,
    input  logic                                   rst_i,
    input  logic                                   bus_stop_n_i,
    input  logic                                   cpu_stop_n_i,
    input  logic                                   pwrdn_n_i,
    input  logic                                   wr_en_i,
    input  logic [ADDR_W-1:0]                      addr_i,
    input  logic [clkstop_pkg::data_width(FREE_N)-1:0] wr_data_i,
    output logic [clkstop_pkg::data_width(FREE_N)-1:0] rd_data_o,
    output logic [BUS_N-1:0]                       bus_clk_o,
    output logic [FREE_N-1:0]                      free_clk_o,
    output logic [CPU_N-1:0]                       cpu_clk_o,
    output logic [CPU_N-1:0]                       cpu_oe_o
);
    localparam int unsigned DW = data_width(FREE_N);

    logic [2:0]        pins_s;      // {bus, cpu, pwrdn}, active low
    ctrl_t             ctrl;
    logic [FREE_N-1:0] free_mask;
    req_t              req;
    logic              tick, rise;
    logic              bus_allow, cpu_allow;
    logic [BUS_N-1:0]  bus_park;
    logic [FREE_N-1:0] free_park;
    logic [CPU_N-1:0]  cpu_park;

    clkstop_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({bus_stop_n_i, cpu_stop_n_i, pwrdn_n_i}),
        .q_o   (pins_s)
    );

    clkstop_regs #(.FREE_N(FREE_N)) u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i[DW-1:0]),
        .bus_pin_i (pins_s[2]),
        .ctrl_o    (ctrl),
        .mask_o    (free_mask),
        .rd_data_o (rd_data_o)
    );

    clkstop_div #(.HALF(HALF)) u_div (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (tick),
        .rise_o (rise)
    );

    // Stop when either the pin or the register bit is low.
    always_comb begin
        req.bus_stop = !(pins_s[2] && ctrl.bus_run);
        req.cpu_stop = !pins_s[1];
        req.pwr_down = !pins_s[0];
    end

    assign bus_allow = !req.pwr_down && !req.bus_stop;
    assign cpu_allow = !req.pwr_down && !req.cpu_stop;

    for (genvar i = 0; i < BUS_N; i++) begin : g_bus
        clkstop_gate u_gate (
            .clk_i (clk_i), .rst_i (rst_i), .tick_i (tick), .rise_i (rise),
            .allow_i (bus_allow), .clk_o (bus_clk_o[i]), .parked_o (bus_park[i])
        );
    end

    for (genvar j = 0; j < FREE_N; j++) begin : g_free
        clkstop_gate u_gate (
            .clk_i (clk_i), .rst_i (rst_i), .tick_i (tick), .rise_i (rise),
            .allow_i (free_allow(req, free_mask[j])),
            .clk_o (free_clk_o[j]), .parked_o (free_park[j])
        );

        // R4: a free output parks only if masked into the stop or powered down
        p_free_park_cause_r4: assert property (@(posedge clk_i) disable iff (rst_i)
            $rose(free_park[j]) |-> (!$past(free_mask[j]) || $past(req.pwr_down)))
            else $error("free-running output parked");
    end

    for (genvar k = 0; k < CPU_N; k++) begin : g_cpu
        clkstop_gate u_gate (
            .clk_i (clk_i), .rst_i (rst_i), .tick_i (tick), .rise_i (rise),
            .allow_i (cpu_allow), .clk_o (cpu_clk_o[k]), .parked_o (cpu_park[k])
        );
        assign cpu_oe_o[k] = !(ctrl.cpu_hiz && cpu_park[k]);

        // R7: an output is only released while it sits low
        p_oe_low_r7: assert property (@(posedge clk_i) disable iff (rst_i)
            !cpu_oe_o[k] |-> !cpu_clk_o[k])
            else $error("released processor output is high");
    end

    // R3: all bus outputs park and restart together
    p_bus_lockstep_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_park == {BUS_N{bus_park[0]}}) && (bus_clk_o == {BUS_N{bus_clk_o[0]}}))
        else $error("bus outputs out of step");
endmodule

// File: tb/clkstop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb_top;
    localparam int HALF   = 2;
    localparam int BUS_N  = 4;
    localparam int FREE_N = 3;
    localparam int CPU_N  = 2;
    localparam int DW     = (FREE_N > 2) ? FREE_N : 2;
    localparam int SETTLE = 2 + 2 * HALF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_pin = 1'b1, cpu_pin = 1'b1, pd_pin = 1'b1;
    logic wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [BUS_N-1:0]  bus_clk;
    logic [FREE_N-1:0] free_clk;
    logic [CPU_N-1:0]  cpu_clk, cpu_oe;

    // bench copy of register contents, from the writes it makes
    logic m_run = 1'b1, m_hiz = 1'b0;
    logic [FREE_N-1:0] m_mask = '1;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    clkstop_ctrl #(.HALF(HALF), .BUS_N(BUS_N), .FREE_N(FREE_N), .CPU_N(CPU_N)) dut_i (
        .clk_i(clk), .rst_i(rst), .bus_stop_n_i(bus_pin), .cpu_stop_n_i(cpu_pin),
        .pwrdn_n_i(pd_pin), .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .bus_clk_o(bus_clk), .free_clk_o(free_clk),
        .cpu_clk_o(cpu_clk), .cpu_oe_o(cpu_oe)
    );

    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R5: high-pulse width monitor on one output of each group
    int hi_len [3] = '{0, 0, 0};
    always @(negedge clk) begin
        logic [2:0] probe;
        probe = {cpu_clk[0], free_clk[0], bus_clk[0]};
        for (int g = 0; g < 3; g++) begin
            if (probe[g]) hi_len[g]++;
            else if (hi_len[g] != 0) begin
                check(hi_len[g] == HALF, "R5 high pulse width", hi_len[g], HALF);
                hi_len[g] = 0;
            end
        end
    end

    function automatic logic div_phase(input int c);
        return ((c / HALF) % 2) == 1;
    endfunction
    function automatic logic bus_runs();
        return pd_pin && bus_pin && m_run;
    endfunction
    function automatic logic free_runs(input int j);
        return pd_pin && (m_mask[j] || (bus_pin && m_run));
    endfunction
    function automatic logic cpu_runs();
        return pd_pin && cpu_pin;
    endfunction

    task automatic write_reg(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd0) begin m_run = d[0]; m_hiz = d[1]; end
        else if (a == 2'd1) m_mask = d[FREE_N-1:0];
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [DW-1:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    // compare every output with its expectation over two output periods
    task automatic window(input string tag);
        logic [BUS_N-1:0] eb; logic [FREE_N-1:0] ef; logic [CPU_N-1:0] ec, eo;
        bit okb = 1, okf = 1, okc = 1, oko = 1;
        logic [BUS_N-1:0] ab; logic [FREE_N-1:0] af; logic [CPU_N-1:0] ac, ao;
        for (int s = 0; s < 4 * HALF; s++) begin
            @(negedge clk);
            eb = bus_runs() ? {BUS_N{div_phase(cyc)}} : '0;
            for (int j = 0; j < FREE_N; j++) ef[j] = free_runs(j) && div_phase(cyc);
            ec = cpu_runs() ? {CPU_N{div_phase(cyc)}} : '0;
            eo = (cpu_runs() || !m_hiz) ? '1 : '0;
            if (bus_clk != eb) begin okb = 0; ab = bus_clk; end
            if (free_clk != ef) begin okf = 0; af = free_clk; end
            if (cpu_clk != ec) begin okc = 0; ac = cpu_clk; end
            if (cpu_oe != eo) begin oko = 0; ao = cpu_oe; end
        end
        check(okb, {tag, " R3 bus outputs"}, int'(ab), int'(eb));
        check(okf, {tag, " R4 free outputs"}, int'(af), int'(ef));
        check(okc, {tag, " R7 processor outputs"}, int'(ac), int'(ec));
        check(oko, {tag, " R7 processor enables"}, int'(ao), int'(eo));
    endtask

    task automatic status_check(input string tag);
        logic [DW-1:0] v;
        read_reg(2'd0, v);
        check(v[0] == (bus_pin && m_run), {tag, " R2 stop readback"}, int'(v[0]), int'(bus_pin && m_run));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'h5eed_c10c));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state and start-up phase
        read_reg(2'd0, v);
        check(v == DW'(1), "R1 control reset value", int'(v), 1);
        read_reg(2'd1, v);
        check(v[FREE_N-1:0] == '1, "R1 mask reset value", int'(v), (1 << FREE_N) - 1);
        repeat (HALF - 1) @(negedge clk);
        check(bus_clk == '0, "R1 low before first edge", int'(bus_clk), 0);
        @(negedge clk);
        check(bus_clk == '1 && cpu_clk == '1 && free_clk == '1, "R1 first high at HALF",
              int'(bus_clk), (1 << BUS_N) - 1);
        window("R1 reset");

        // R2: two-edge readback latency of the pin
        bus_pin = 1'b0;
        @(negedge clk); read_reg(2'd0, v);
        check(v[0] == 1'b1, "R2 readback after one edge", int'(v[0]), 1);
        @(negedge clk); read_reg(2'd0, v);
        check(v[0] == 1'b0, "R2 readback after two edges", int'(v[0]), 0);
        repeat (SETTLE) @(negedge clk);
        window("R3 pin stop");
        bus_pin = 1'b1;
        repeat (SETTLE) @(negedge clk);
        window("R6 pin release");

        // R2/R3: register bit alone stops, readback follows the write at once
        write_reg(2'd0, 2'b00);
        read_reg(2'd0, v);
        check(v[0] == 1'b0, "R2 readback of cleared bit", int'(v[0]), 0);
        write_reg(2'd1, 3'b010);
        repeat (SETTLE) @(negedge clk);
        window("R4 masked stop");
        write_reg(2'd0, 2'b01);
        write_reg(2'd1, '1);

        // R6: release bound at every phase offset
        for (int off = 0; off < 2 * HALF; off++) begin
            bus_pin = 1'b0;
            repeat (SETTLE + off) @(negedge clk);
            bus_pin = 1'b1;
            repeat (SETTLE) @(negedge clk);
            check(bus_clk[0] == div_phase(cyc), "R6 running within bound",
                  int'(bus_clk[0]), int'(div_phase(cyc)));
            window("R6 release");
        end

        // R7: processor stop, driven and released
        cpu_pin = 1'b0;
        repeat (SETTLE) @(negedge clk);
        window("R7 driven");
        write_reg(2'd0, 2'b11);
        repeat (SETTLE) @(negedge clk);
        window("R7 released");
        cpu_pin = 1'b1;
        repeat (SETTLE) @(negedge clk);
        window("R7 restart");

        // R8: power-down halts even free-running outputs
        pd_pin = 1'b0;
        repeat (SETTLE) @(negedge clk);
        window("R8 power-down");
        pd_pin = 1'b1;
        write_reg(2'd0, 2'b01);
        repeat (SETTLE) @(negedge clk);
        window("R8 wake");

        // R9: unmapped addresses
        write_reg(2'd2, '1);
        write_reg(2'd3, '0);
        read_reg(2'd2, v);
        check(v == '0, "R9 unmapped read", int'(v), 0);
        read_reg(2'd0, v);
        check(v == DW'(1), "R9 control unchanged", int'(v), 1);
        read_reg(2'd1, v);
        check(v[FREE_N-1:0] == '1, "R9 mask unchanged", int'(v), (1 << FREE_N) - 1);

        // random configurations
        for (int it = 0; it < 40; it++) begin
            write_reg(2'd0, DW'($urandom_range(0, 3)));
            write_reg(2'd1, DW'($urandom_range(0, (1 << FREE_N) - 1)));
            repeat ($urandom_range(0, 3)) @(negedge clk);
            bus_pin = ($urandom_range(0, 2) != 0);
            cpu_pin = ($urandom_range(0, 2) != 0);
            pd_pin  = ($urandom_range(0, 4) != 0);
            repeat (SETTLE) @(negedge clk);
            status_check("random");
            window("random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule